// File: doc/BRIEF.md
# Fail-First Vector Length Truncator

This block steps through the elements of a vector operation in order and decides how far the operation gets. Elements are organised as `cfg_len` sub-groups, each holding `cfg_sub_m1 + 1` elements. One predicate bit belongs to each sub-group. For every element that has to be examined, the block places its group index and its sub-element offset on a request/acknowledge handshake. The execution side answers with a trap flag or with a test result. The block itself never performs the element operation.

The block runs in one of two modes, and an operation uses exactly one of them. In trap mode, a fault on the first sub-group is passed on as an ordinary trap. A fault on any later sub-group cancels that sub-group and every sub-group after it, and the vector length is cut to the number of sub-groups before it. In conditional mode, a failing test ends the operation and cuts the length in the same way. When zeroing predication is selected, a masked-out sub-group counts as an automatic failure. Sub-groups that are masked out and not failed still count toward the new length.

When the operation ends, a one-cycle `done` pulse is raised together with the new length. If an element failed, the block also records its group index and sub-element offset, so a trap handler can find it. These results hold until the next accepted start.

Top module: `ff_vlen_trunc`

## Requirements
- R1: After reset, `busy`, `done`, `elem_req`, `trap_raise` and `fault_valid` are 0, and `trunc_len` is 0.
- R2: `start` is sampled only while `busy` is 0. A length of 0 gives a `done` pulse with `trunc_len` = 0, no request, no trap and `fault_valid` = 0, in the second cycle after the start edge.
- R3: When no element fails, `trunc_len` equals the requested length, and `done` pulses for one cycle after the last sub-group. Lengths above MAX_LEN are clamped to MAX_LEN.
- R4: Trap mode (`cfg_cond` = 0): `elem_trap` = 1 on an acknowledged element of sub-group g > 0 stops processing. No further element is requested, and `trunc_len` = g with `trap_raise` = 0.
- R5: Trap mode: a trap on any element of sub-group 0 asserts `trap_raise` with `done`, and `trunc_len` keeps the full length.
- R6: A sub-group whose `cfg_mask` bit is 0 is never requested and cannot trap. It still counts toward `trunc_len`, and trap mode gives the same result whether `cfg_zero` is 0 or 1.
- R7: Conditional mode (`cfg_cond` = 1, `cfg_zero` = 0): `elem_pass` = 0 on an acknowledged element of sub-group g stops processing with `trunc_len` = g and no trap, including g = 0. A masked-out sub-group is skipped and never fails.
- R8: Conditional mode with `cfg_zero` = 1: the first masked-out sub-group g fails at once, giving `trunc_len` = g and recording sub-element offset 0.
- R9: Elements are requested with the offset running 0 to `cfg_sub_m1` inside each sub-group. A failure at any offset removes the whole sub-group from `trunc_len`. This includes a failure on the very last element.
- R10: On a failure, `fault_valid` = 1 and `fault_grp`/`fault_sub` give the failing element. All results stay stable while idle until the next accepted start, which clears `fault_valid` and `trap_raise`.
- R11: A request stays asserted, with the same indices, until `elem_ack` is 1. `elem_ack`, `elem_trap` and `elem_pass` are ignored while `elem_req` is 0.
- R12: A `start` while `busy` is 1 has no effect on the running operation or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| cfg_len | input | LEN_W | Number of sub-groups |
| cfg_sub_m1 | input | SUB_W | Elements per sub-group minus one |
| cfg_cond | input | 1 | 0 = trap mode, 1 = conditional mode |
| cfg_zero | input | 1 | Zeroing predication |
| cfg_mask | input | MAX_LEN | Predicate, one bit per sub-group |
| elem_req | output | 1 | Element status requested |
| elem_grp | output | IDX_W | Sub-group index of the requested element |
| elem_sub | output | SUB_W | Offset inside the sub-group |
| elem_ack | input | 1 | Element status valid |
| elem_trap | input | 1 | Element raised a trap |
| elem_pass | input | 1 | Element test passed (result nonzero) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trunc_len | output | LEN_W | Resulting vector length |
| trap_raise | output | 1 | Real trap from sub-group 0 |
| fault_valid | output | 1 | A failing element was recorded |
| fault_grp | output | IDX_W | Sub-group of the failing element |
| fault_sub | output | SUB_W | Offset of the failing element |

## Verification
The hardest case is a failure on the last element of the last sub-group. In that cycle the end of the vector and a failure are decided at the same moment. The failure has to win, so the sub-group is dropped and the length comes out one short. The bench provokes this in conditional mode with two-element sub-groups, where the first element of the last sub-group passes and the second fails. A second collision comes from a trap driven on a masked-out sub-group in the same cycle that the skip takes place. A cycle-level reference model is compared on every clock, and an explicit check is made at each `done` pulse.

// File: rtl/ffvt_pkg.sv
package ffvt_pkg;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_RUN  = 1'b1
   } fsm_e;

   // per-cycle decision taken by the judge
   typedef enum logic [2:0] {
      ACT_HOLD = 3'd0,   // waiting for an acknowledge
      ACT_ELEM = 3'd1,   // element passed, advance one element
      ACT_GRP  = 3'd2,   // masked sub-group skipped
      ACT_FAIL = 3'd3,   // failure detected at current position
      ACT_END  = 3'd4    // all sub-groups walked
   } act_e;

   function automatic int unsigned sub_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ffvt_cursor.sv
module ffvt_cursor
   import ffvt_pkg::*;
#(
   parameter int unsigned MAX_LEN = 64,
   parameter int unsigned MAX_SUB = 4,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned SUB_W  = sub_bits(MAX_SUB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step_elem,
   input  logic             step_grp,
   input  logic [SUB_W-1:0] sub_m1,
   output logic [LEN_W-1:0] grp,
   output logic [SUB_W-1:0] sub,
   output logic             sub_last
);

   logic grp_inc;
   assign grp_inc = step_grp || (step_elem && sub_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       grp <= '0;
      else if (load)    grp <= '0;
      else if (grp_inc) grp <= grp + 1'b1;
   end

   generate
      if (MAX_SUB > 1) begin : g_sub_cnt
         assign sub_last = (sub == sub_m1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    sub <= '0;
            else if (load || step_grp)     sub <= '0;
            else if (step_elem) begin
               if (sub_last) sub <= '0;
               else          sub <= sub + 1'b1;
            end
         end
      end else begin : g_sub_none
         logic unused_sub_m1;
         assign unused_sub_m1 = ^sub_m1;
         assign sub      = '0;
         assign sub_last = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ffvt_judge.sv
module ffvt_judge
   import ffvt_pkg::*;
#(
   parameter int unsigned MAX_LEN = 64,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic             run,
   input  logic [LEN_W-1:0] grp,
   input  logic [LEN_W-1:0] len,
   input  logic             mask_bit,
   input  logic             cond,
   input  logic             zero,
   input  logic             ack,
   input  logic             trap,
   input  logic             pass,
   output logic             req,
   output act_e             act
);

   logic at_end;
   logic fail_now;

   assign at_end   = (grp == len);
   // trap mode ignores the test result, conditional mode ignores traps
   assign fail_now = cond ? !pass : trap;

   always_comb begin
      req = 1'b0;
      act = ACT_HOLD;
      if (run) begin
         if (at_end) begin
            act = ACT_END;
         end else if (!mask_bit) begin
            act = (cond && zero) ? ACT_FAIL : ACT_GRP;
         end else begin
            req = 1'b1;
            if (ack) act = fail_now ? ACT_FAIL : ACT_ELEM;
         end
      end
   end

endmodule

// File: rtl/ffvt_result.sv
module ffvt_result
   import ffvt_pkg::*;
#(
   parameter int unsigned MAX_LEN = 64,
   parameter int unsigned MAX_SUB = 4,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned IDX_W  = $clog2(MAX_LEN),
   localparam int unsigned SUB_W  = sub_bits(MAX_SUB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  act_e             act,
   input  logic             cond,
   input  logic [LEN_W-1:0] grp,
   input  logic [SUB_W-1:0] sub,
   input  logic [LEN_W-1:0] len,
   output logic             done,
   output logic [LEN_W-1:0] trunc_len,
   output logic             trap_raise,
   output logic             fault_valid,
   output logic [IDX_W-1:0] fault_grp,
   output logic [SUB_W-1:0] fault_sub
);

   logic first_grp;
   logic finish;

   assign first_grp = (grp == '0);
   assign finish    = (act == ACT_END) || (act == ACT_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done        <= 1'b0;
         trunc_len   <= '0;
         trap_raise  <= 1'b0;
         fault_valid <= 1'b0;
         fault_grp   <= '0;
         fault_sub   <= '0;
      end else begin
         done <= finish;
         if (clear) begin
            trap_raise  <= 1'b0;
            fault_valid <= 1'b0;
         end else if (act == ACT_END) begin
            trunc_len <= len;
         end else if (act == ACT_FAIL) begin
            fault_valid <= 1'b1;
            fault_grp   <= grp[IDX_W-1:0];
            fault_sub   <= sub;
            if (!cond && first_grp) begin
               // leading sub-group faults behave like a scalar trap
               trap_raise <= 1'b1;
               trunc_len  <= len;
            end else begin
               trunc_len  <= grp;
            end
         end
      end
   end

endmodule

// File: rtl/ff_vlen_trunc.sv
module ff_vlen_trunc
   import ffvt_pkg::*;
#(
   parameter int unsigned MAX_LEN = 64,
   parameter int unsigned MAX_SUB = 4,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned IDX_W  = $clog2(MAX_LEN),
   localparam int unsigned SUB_W  = sub_bits(MAX_SUB)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LEN_W-1:0]   cfg_len,
   input  logic [SUB_W-1:0]   cfg_sub_m1,
   input  logic               cfg_cond,
   input  logic               cfg_zero,
   input  logic [MAX_LEN-1:0] cfg_mask,
   output logic               elem_req,
   output logic [IDX_W-1:0]   elem_grp,
   output logic [SUB_W-1:0]   elem_sub,
   input  logic               elem_ack,
   input  logic               elem_trap,
   input  logic               elem_pass,
   output logic               busy,
   output logic               done,
   output logic [LEN_W-1:0]   trunc_len,
   output logic               trap_raise,
   output logic               fault_valid,
   output logic [IDX_W-1:0]   fault_grp,
   output logic [SUB_W-1:0]   fault_sub
);

   generate
      if (MAX_LEN < 2) begin : g_bad_len
         $error("ff_vlen_trunc: MAX_LEN must be at least 2");
      end
      if ((MAX_SUB < 1) || ((MAX_SUB & (MAX_SUB - 1)) != 0)) begin : g_bad_sub
         $error("ff_vlen_trunc: MAX_SUB must be a power of two");
      end
   endgenerate

   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

   fsm_e               state;
   logic [LEN_W-1:0]   len_q;
   logic [SUB_W-1:0]   sm1_q;
   logic               cond_q;
   logic               zero_q;
   logic [MAX_LEN-1:0] mask_q;
   logic               accept;
   logic [LEN_W-1:0]   len_in;
   logic [LEN_W-1:0]   grp;
   logic [SUB_W-1:0]   sub;
   logic               sub_last;
   logic               mask_bit;
   act_e               act;

   assign accept = (state == FS_IDLE) && start;
   assign len_in = (cfg_len > LEN_CAP) ? LEN_CAP : cfg_len;
   assign busy   = (state == FS_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= FS_IDLE;
         len_q  <= '0;
         sm1_q  <= '0;
         cond_q <= 1'b0;
         zero_q <= 1'b0;
         mask_q <= '0;
      end else if (accept) begin
         state  <= FS_RUN;
         len_q  <= len_in;
         sm1_q  <= cfg_sub_m1;
         cond_q <= cfg_cond;
         zero_q <= cfg_zero;
         mask_q <= cfg_mask;
      end else if ((act == ACT_END) || (act == ACT_FAIL)) begin
         state  <= FS_IDLE;
      end
   end

   ffvt_cursor #(.MAX_LEN(MAX_LEN), .MAX_SUB(MAX_SUB)) u_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .step_elem (act == ACT_ELEM),
      .step_grp  (act == ACT_GRP),
      .sub_m1    (sm1_q),
      .grp       (grp),
      .sub       (sub),
      .sub_last  (sub_last)
   );

   assign mask_bit = mask_q[grp[IDX_W-1:0]];

   ffvt_judge #(.MAX_LEN(MAX_LEN)) u_judge (
      .run      (busy),
      .grp      (grp),
      .len      (len_q),
      .mask_bit (mask_bit),
      .cond     (cond_q),
      .zero     (zero_q),
      .ack      (elem_ack),
      .trap     (elem_trap),
      .pass     (elem_pass),
      .req      (elem_req),
      .act      (act)
   );

   assign elem_grp = grp[IDX_W-1:0];
   assign elem_sub = sub;

   ffvt_result #(.MAX_LEN(MAX_LEN), .MAX_SUB(MAX_SUB)) u_result (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (accept),
      .act         (act),
      .cond        (cond_q),
      .grp         (grp),
      .sub         (sub),
      .len         (len_q),
      .done        (done),
      .trunc_len   (trunc_len),
      .trap_raise  (trap_raise),
      .fault_valid (fault_valid),
      .fault_grp   (fault_grp),
      .fault_sub   (fault_sub)
   );

   logic unused_sub_last;
   assign unused_sub_last = sub_last;

endmodule

// File: rtl/ffvt_chk.sv
module ffvt_chk #(
   parameter int unsigned MAX_LEN = 64,
   parameter int unsigned MAX_SUB = 4,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned IDX_W  = $clog2(MAX_LEN),
   localparam int unsigned SUB_W  = ffvt_pkg::sub_bits(MAX_SUB)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             elem_req,
   input logic [IDX_W-1:0] elem_grp,
   input logic [SUB_W-1:0] elem_sub,
   input logic             elem_ack,
   input logic             busy,
   input logic             done,
   input logic [LEN_W-1:0] trunc_len,
   input logic             trap_raise,
   input logic             fault_valid,
   input logic [IDX_W-1:0] fault_grp,
   input logic [SUB_W-1:0] fault_sub
);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_req && !elem_ack |=> elem_req && $stable(elem_grp) && $stable(elem_sub));

   // R11
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_req |-> busy);

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !elem_req);

   // R5
   trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && trap_raise |-> fault_valid && (fault_grp == '0));

   // R4
   trunc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault_valid && !trap_raise |-> trunc_len == LEN_W'(fault_grp));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(trunc_len) && $stable(fault_grp)
                          && $stable(fault_sub) && $stable(fault_valid));

endmodule

bind ff_vlen_trunc ffvt_chk #(.MAX_LEN(MAX_LEN), .MAX_SUB(MAX_SUB)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .elem_req    (elem_req),
   .elem_grp    (elem_grp),
   .elem_sub    (elem_sub),
   .elem_ack    (elem_ack),
   .busy        (busy),
   .done        (done),
   .trunc_len   (trunc_len),
   .trap_raise  (trap_raise),
   .fault_valid (fault_valid),
   .fault_grp   (fault_grp),
   .fault_sub   (fault_sub)
);

// File: tb/ff_vlen_trunc_bench.sv
module ff_vlen_trunc_bench;

   localparam int MAX_LEN = 64;
   localparam int MAX_SUB = 4;
   localparam int LEN_W   = 7;
   localparam int IDX_W   = 6;
   localparam int SUB_W   = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [LEN_W-1:0]   cfg_len = '0;
   logic [SUB_W-1:0]   cfg_sub_m1 = '0;
   logic               cfg_cond = 1'b0;
   logic               cfg_zero = 1'b0;
   logic [MAX_LEN-1:0] cfg_mask = '0;
   logic               elem_ack = 1'b0;
   logic               elem_trap = 1'b0;
   logic               elem_pass = 1'b1;
   logic               elem_req;
   logic [IDX_W-1:0]   elem_grp;
   logic [SUB_W-1:0]   elem_sub;
   logic               busy;
   logic               done;
   logic [LEN_W-1:0]   trunc_len;
   logic               trap_raise;
   logic               fault_valid;
   logic [IDX_W-1:0]   fault_grp;
   logic [SUB_W-1:0]   fault_sub;

   always #5 clk = ~clk;

   ff_vlen_trunc #(.MAX_LEN(MAX_LEN), .MAX_SUB(MAX_SUB)) u_ff_vlen_trunc (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
      .cfg_sub_m1(cfg_sub_m1), .cfg_cond(cfg_cond), .cfg_zero(cfg_zero),
      .cfg_mask(cfg_mask), .elem_req(elem_req), .elem_grp(elem_grp),
      .elem_sub(elem_sub), .elem_ack(elem_ack), .elem_trap(elem_trap),
      .elem_pass(elem_pass), .busy(busy), .done(done), .trunc_len(trunc_len),
      .trap_raise(trap_raise), .fault_valid(fault_valid),
      .fault_grp(fault_grp), .fault_sub(fault_sub)
   );

   bit    tr_tab [MAX_LEN*MAX_SUB];
   bit    ps_tab [MAX_LEN*MAX_SUB];
   int    stall_mod = 0;
   int    cyc = 0;
   int    errors = 0;
   int    checks = 0;
   string cur_tag = "R1";
   bit    start_next = 1'b0;

   // behavioural reference model, advanced on every rising edge
   int          m_st = 0, m_g = 0, m_s = 0, m_len = 0, m_sm1 = 0;
   bit          m_cond = 0, m_zero = 0, m_done = 0, m_trap = 0, m_fv = 0;
   logic [63:0] m_mask = '0;
   int          m_trunc = 0, m_fg = 0, m_fs = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_g = 0; m_s = 0; m_done = 0; m_trap = 0; m_fv = 0;
         m_trunc = 0; m_fg = 0; m_fs = 0;
      end else begin
         m_done = 0;
         if (m_st == 0) begin
            if (start) begin
               m_len  = (int'(cfg_len) > MAX_LEN) ? MAX_LEN : int'(cfg_len);
               m_sm1  = int'(cfg_sub_m1);
               m_cond = cfg_cond;
               m_zero = cfg_zero;
               m_mask = cfg_mask;
               m_g = 0; m_s = 0; m_fv = 0; m_trap = 0;
               m_st = 1;
            end
         end else begin
            bit failed;
            failed = 0;
            if (m_g == m_len) begin
               m_trunc = m_len; m_st = 0; m_done = 1;
            end else if (!m_mask[m_g]) begin
               if (m_cond && m_zero) failed = 1;
               else begin m_g++; m_s = 0; end
            end else if (elem_ack) begin
               if (m_cond ? !elem_pass : elem_trap) failed = 1;
               else if (m_s == m_sm1) begin m_g++; m_s = 0; end
               else m_s++;
            end
            if (failed) begin
               m_fv = 1; m_fg = m_g; m_fs = m_s; m_st = 0; m_done = 1;
               if (!m_cond && m_g == 0) begin m_trap = 1; m_trunc = m_len; end
               else m_trunc = m_g;
            end
         end
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic compare_cycle();
      bit exp_req;
      exp_req = (m_st == 1) && (m_g < m_len) && m_mask[m_g];
      check(cur_tag, "busy", busy, m_st);
      check(cur_tag, "done", done, m_done);
      check("R11", "elem_req", elem_req, exp_req);
      if (exp_req) begin
         check("R9", "elem_grp", elem_grp, m_g);
         check("R9", "elem_sub", elem_sub, m_s);
      end
      check(cur_tag, "trunc_len", trunc_len, m_trunc);
      check(cur_tag, "trap_raise", trap_raise, m_trap);
      check("R10", "fault_valid", fault_valid, m_fv);
      if (m_fv) begin
         check("R10", "fault_grp", fault_grp, m_fg);
         check("R10", "fault_sub", fault_sub, m_fs);
      end
   endtask

   task automatic step();
      int idx;
      @(negedge clk);
      cyc++;
      start = start_next;
      start_next = 1'b0;
      elem_ack = (stall_mod == 0) || ((cyc % stall_mod) != 0);
      idx = m_g * MAX_SUB + m_s;
      if (m_g < MAX_LEN) begin
         elem_trap = tr_tab[idx];
         elem_pass = ps_tab[idx];
      end else begin
         elem_trap = 1'b0;
         elem_pass = 1'b1;
      end
      #2;
      compare_cycle();
   endtask

   task automatic clear_tabs();
      for (int i = 0; i < MAX_LEN*MAX_SUB; i++) begin
         tr_tab[i] = 1'b0;
         ps_tab[i] = 1'b1;
      end
   endtask

   task automatic run_case(string tag, int len, int sm1, bit cond, bit zero,
                           logic [63:0] mask, int stall, int inject, int exp_lat,
                           int exp_trunc, bit exp_trap, bit exp_fv,
                           int exp_fg, int exp_fs);
      int n;
      bit got;
      cur_tag    = tag;
      cfg_len    = LEN_W'(len);
      cfg_sub_m1 = SUB_W'(sm1);
      cfg_cond   = cond;
      cfg_zero   = zero;
      cfg_mask   = mask;
      stall_mod  = stall;
      start_next = 1'b1;
      n = 0;
      got = 0;
      while (!got && n < 400) begin
         step();
         n++;
         if (n == inject) begin
            start_next = 1'b1;
            cfg_len    = LEN_W'(2);
            cfg_cond   = ~cfg_cond;
         end
         if (done) got = 1;
      end
      check(tag, "done seen", got, 1);
      if (exp_lat > 0) check(tag, "latency", n, exp_lat);
      check(tag, "final trunc_len", trunc_len, exp_trunc);
      check(tag, "final trap_raise", trap_raise, exp_trap);
      check(tag, "final fault_valid", fault_valid, exp_fv);
      if (exp_fv) begin
         check(tag, "final fault_grp", fault_grp, exp_fg);
         check(tag, "final fault_sub", fault_sub, exp_fs);
      end
      step();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      clear_tabs();
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      check("R1", "busy", busy, 0);
      check("R1", "done", done, 0);
      check("R1", "elem_req", elem_req, 0);
      check("R1", "trap_raise", trap_raise, 0);
      check("R1", "fault_valid", fault_valid, 0);
      check("R1", "trunc_len", trunc_len, 0);
      @(negedge clk);
      rst_n = 1'b1;
      step();

      // R2 zero length
      run_case("R2", 0, 0, 0, 0, '1, 0, 0, 3, 0, 0, 0, 0, 0);

      // R3 no failure, and clamp of an oversize length
      run_case("R3", 5, 0, 0, 0, '1, 0, 0, 0, 5, 0, 0, 0, 0);
      run_case("R3", 100, 0, 1, 0, '1, 0, 0, 0, 64, 0, 0, 0, 0);

      // R4 later trap truncates, with a stalling acknowledge (R11)
      clear_tabs(); tr_tab[3*4] = 1'b1;
      run_case("R4", 8, 0, 0, 0, '1, 3, 0, 0, 3, 0, 1, 3, 0);

      // R5 trap on the leading sub-group
      clear_tabs(); tr_tab[0] = 1'b1;
      run_case("R5", 8, 0, 0, 0, '1, 0, 0, 0, 8, 1, 1, 0, 0);

      // R6 masked groups 1,2 skipped; trap driven on group 2 ignored; zero flag set
      clear_tabs(); tr_tab[2*4] = 1'b1; tr_tab[5*4] = 1'b1;
      run_case("R6", 8, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFF9, 0, 0, 0, 5, 0, 1, 5, 0);

      // R7 conditional, non-zeroing: masked group 3 not failed, group 6 fails
      clear_tabs(); ps_tab[3*4] = 1'b0; ps_tab[6*4] = 1'b0;
      run_case("R7", 10, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFF7, 2, 0, 0, 6, 0, 1, 6, 0);

      // R7 conditional failure on group 0 gives length 0 without a trap
      clear_tabs(); ps_tab[0] = 1'b0;
      run_case("R7", 4, 0, 1, 0, '1, 0, 0, 0, 0, 0, 1, 0, 0);

      // R8 zeroing: masked group 4 fails unconditionally
      clear_tabs();
      run_case("R8", 9, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFEF, 0, 0, 0, 4, 0, 1, 4, 0);

      // R9 sub-groups of 3, group 1 masked, trap at group 2 offset 2
      clear_tabs(); tr_tab[2*4+2] = 1'b1;
      run_case("R9", 4, 2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFD, 0, 0, 0, 2, 0, 1, 2, 2);

      // R9 failure on the very last element collides with end of vector
      clear_tabs(); ps_tab[2*4+1] = 1'b0;
      run_case("R9", 3, 1, 1, 0, '1, 0, 0, 0, 2, 0, 1, 2, 1);

      // R12 start while busy is ignored
      clear_tabs(); tr_tab[3*4] = 1'b1;
      run_case("R12", 8, 0, 0, 0, '1, 0, 2, 0, 3, 0, 1, 3, 0);

      // R10 result held while idle, cleared by next start
      cur_tag = "R10";
      repeat (4) step();
      check("R10", "held trunc_len", trunc_len, 3);
      check("R10", "held fault_grp", fault_grp, 3);
      clear_tabs();
      run_case("R10", 2, 0, 0, 0, '1, 0, 0, 0, 2, 0, 0, 0, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule